// File: doc/BRIEF.md
# Float Immediate Load Unit

This execution unit turns two 32-bit instructions into double-precision constants for a floating-point register file. Each instruction holds a 16-bit immediate scattered over three fields. The base load uses the immediate as the upper half of a single-precision word, with the lower half zero. It widens that word to double precision and writes it to the target register. The extend instruction is a read-modify-write. It reads the target register and narrows its double value to single format by truncation, keeping the top 16 bits. It places the new immediate below them, widens the full single word to double, and writes it back.

Software builds an exact single-precision constant with a base load followed by an extend to the same register. A base load on its own gives a constant with a short mantissa. The unit takes one instruction at a time over a valid/ready handshake. It drives a register read port (enable, address, data returned in the same cycle) and a register write port (enable, address, data).

Top module: `fimm_unit`

## Requirements
- R1: Instruction fields, with bit 31 as the most significant bit: the major opcode is insn[31:26], the target register is insn[25:21], and the extended opcode is insn[5:1]. The 16-bit immediate is {insn[15:6], insn[20:16], insn[0]}, so insn[15] is its most significant bit and insn[0] is its least significant bit.
- R2: A base load (major opcode 22, extended opcode 3) writes the widened value of {imm, 16'h0000} to the target register. wr_en is high in the cycle after acceptance.
- R3: A normal single value keeps its sign. Its exponent is rebiased by adding 896, and its 23-bit mantissa lands in the top of the 52-bit double mantissa with 29 zeros below it.
- R4: A single-precision subnormal is normalised. With its leading one at mantissa bit p, the double exponent is 874+p and the bits below the leading one move to the top of the double mantissa.
- R5: A single exponent of 255 gives double exponent 2047, with the mantissa payload kept (shifted by 29). Signed zeros stay signed zeros.
- R6: An extend (major opcode 22, extended opcode 4) asserts rd_en with rd_addr equal to the target in the cycle after acceptance, and asserts wr_en to the same register in the cycle after that.
- R7: A base load followed by an extend on the same register writes exactly the single word {first imm, second imm}, widened to double.
- R8: For an extend, the upper 16 bits come from narrowing the register's double by truncation. Bits beyond single precision are dropped. A magnitude of 2^128 or more becomes the largest finite single. Magnitudes below the single normal range become single subnormals or zero.
- R9: in_ready is low from acceptance until the cycle after the write. An instruction that directly follows a write to the same register sees the updated value.
- R10: A major opcode other than 22, or an extended opcode other than 3 or 4, pulses illegal in the cycle after acceptance. It causes no read and no write.
- R11: After reset, in_ready is high and rd_en, wr_en and illegal are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can accept an instruction |
| in_insn | input | 32 | Instruction word |
| rd_en | output | 1 | Register read request |
| rd_addr | output | 5 | Register read address |
| rd_data | input | 64 | Read data, valid in the same cycle |
| wr_en | output | 1 | Register write enable |
| wr_addr | output | 5 | Register write address |
| wr_data | output | 64 | Double-precision result |
| illegal | output | 1 | One-cycle pulse for an unrecognised instruction |

## Verification
The bench covers single subnormals with one or more fraction bits. A design that fails to normalise them writes a zero or wrong exponent. Infinity and NaN immediates are checked, where a plain rebias would corrupt exponent 2047. Extends are applied to registers holding doubles that are too large or too small for single format, or that carry extra low bits. A design that narrows these by rounding or wraps the exponent splices in the wrong upper half. An extend issued directly after a base load to the same register checks that the read follows the write-back. A unit that read too early would pick up the stale value. Illegal encodings must produce no read and no write pulse.

// File: rtl/fimm_pkg.sv
package fimm_pkg;

    localparam int INSN_W  = 32;
    localparam int IMM_W   = 16;
    localparam int RIDX_W  = 5;
    localparam int SP_W    = 32;
    localparam int DP_W    = 64;

    typedef struct packed {
        logic [5:0]        major;
        logic [RIDX_W-1:0] tgt;
        logic [4:0]        d1;
        logic [9:0]        d0;
        logic [4:0]        xo;
        logic              d2;
    } insn_fields_t;

    typedef enum logic [1:0] {
        FOP_BASE,
        FOP_EXT,
        FOP_BAD
    } fop_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE
    } fst_e;

    function automatic logic [IMM_W-1:0] join_imm(input insn_fields_t f);
        return {f.d0, f.d1, f.d2};
    endfunction

endpackage

// File: rtl/fimm_decode.sv
module fimm_decode
    import fimm_pkg::*;
#(
    parameter logic [5:0] MAJOR_OP = 6'd22,
    parameter logic [4:0] XO_BASE  = 5'd3,
    parameter logic [4:0] XO_EXT   = 5'd4
) (
    input  logic [INSN_W-1:0] insn,
    output logic [RIDX_W-1:0] tgt,
    output logic [IMM_W-1:0]  imm,
    output fop_e              op
);
    insn_fields_t f;

    always_comb begin
        f   = insn_fields_t'(insn);
        tgt = f.tgt;
        imm = join_imm(f);
        if (f.major != MAJOR_OP)
            op = FOP_BAD;
        else if (f.xo == XO_BASE)
            op = FOP_BASE;
        else if (f.xo == XO_EXT)
            op = FOP_EXT;
        else
            op = FOP_BAD;
    end
endmodule

// File: rtl/fimm_sp2dp.sv
module fimm_sp2dp
    import fimm_pkg::*;
(
    input  logic [SP_W-1:0] sp,
    output logic [DP_W-1:0] dp
);
    localparam int MANT_W = 23;
    localparam int PAD_W  = 29;

    logic              sgn;
    logic [7:0]        ex;
    logic [MANT_W-1:0] mt;
    logic [4:0]        lead;
    logic [MANT_W-1:0] frac;
    logic [10:0]       sub_ex;

    always_comb begin
        sgn  = sp[31];
        ex   = sp[30:23];
        mt   = sp[22:0];
        lead = '0;
        for (int i = 0; i < MANT_W; i++) begin
            if (mt[i]) lead = 5'(i);
        end
        frac   = mt << (5'd23 - lead);
        sub_ex = 11'd874 + {6'd0, lead};
        if (ex == 8'hFF)
            dp = {sgn, 11'h7FF, mt, {PAD_W{1'b0}}};
        else if (ex == 8'h00 && mt == '0)
            dp = {sgn, 63'd0};
        else if (ex == 8'h00)
            dp = {sgn, sub_ex, frac, {PAD_W{1'b0}}};
        else
            dp = {sgn, {3'd0, ex} + 11'd896, mt, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/fimm_dp2sp_hi.sv
module fimm_dp2sp_hi
    import fimm_pkg::*;
(
    input  logic [DP_W-1:0] dp,
    output logic [15:0]     hi
);
    logic        sgn;
    logic [10:0] ex;
    logic [6:0]  top;
    logic [4:0]  sh;
    logic [7:0]  sub;

    always_comb begin
        sgn = dp[63];
        ex  = dp[62:52];
        top = dp[51:45];
        sh  = 5'(11'd897 - ex);
        sub = {1'b1, top} >> sh;
        if (ex == 11'h7FF) begin
            if (dp[51:0] != '0 && top == '0)
                hi = {sgn, 8'hFF, 7'h40};
            else
                hi = {sgn, 8'hFF, top};
        end else if (ex >= 11'd1151)
            hi = {sgn, 8'hFE, 7'h7F};
        else if (ex >= 11'd897)
            hi = {sgn, 8'(ex - 11'd896), top};
        else if (ex >= 11'd874)
            hi = {sgn, 8'h00, sub[6:0]};
        else
            hi = {sgn, 15'd0};
    end
endmodule

// File: rtl/fimm_unit.sv
module fimm_unit
    import fimm_pkg::*;
#(
    parameter logic [5:0] MAJOR_OP = 6'd22,
    parameter logic [4:0] XO_BASE  = 5'd3,
    parameter logic [4:0] XO_EXT   = 5'd4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [31:0]       in_insn,
    output logic              rd_en,
    output logic [4:0]        rd_addr,
    input  logic [63:0]       rd_data,
    output logic              wr_en,
    output logic [4:0]        wr_addr,
    output logic [63:0]       wr_data,
    output logic              illegal
);
    fst_e              state_q;
    logic [RIDX_W-1:0] tgt_q;
    logic [IMM_W-1:0]  imm_q;
    logic [DP_W-1:0]   res_q;
    logic              illegal_q;

    logic [RIDX_W-1:0] dec_tgt;
    logic [IMM_W-1:0]  dec_imm;
    fop_e              dec_op;
    logic [15:0]       reg_hi;
    logic [SP_W-1:0]   cvt_in;
    logic [DP_W-1:0]   cvt_out;
    logic              accept;

    fimm_decode #(
        .MAJOR_OP(MAJOR_OP),
        .XO_BASE (XO_BASE),
        .XO_EXT  (XO_EXT)
    ) u_dec (
        .insn(in_insn),
        .tgt (dec_tgt),
        .imm (dec_imm),
        .op  (dec_op)
    );

    fimm_dp2sp_hi u_narrow (
        .dp(rd_data),
        .hi(reg_hi)
    );

    // one shared widener: idle feeds the new base word, read feeds the splice
    assign cvt_in = (state_q == ST_READ) ? {reg_hi, imm_q} : {dec_imm, 16'h0000};

    fimm_sp2dp u_widen (
        .sp(cvt_in),
        .dp(cvt_out)
    );

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            tgt_q     <= '0;
            imm_q     <= '0;
            res_q     <= '0;
            illegal_q <= 1'b0;
        end else begin
            illegal_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        case (dec_op)
                            FOP_BASE: begin
                                tgt_q   <= dec_tgt;
                                res_q   <= cvt_out;
                                state_q <= ST_WRITE;
                            end
                            FOP_EXT: begin
                                tgt_q   <= dec_tgt;
                                imm_q   <= dec_imm;
                                state_q <= ST_READ;
                            end
                            default: illegal_q <= 1'b1;
                        endcase
                    end
                end
                ST_READ: begin
                    res_q   <= cvt_out;
                    state_q <= ST_WRITE;
                end
                ST_WRITE: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign in_ready = (state_q == ST_IDLE);
    assign rd_en    = (state_q == ST_READ);
    assign rd_addr  = tgt_q;
    assign wr_en    = (state_q == ST_WRITE);
    assign wr_addr  = tgt_q;
    assign wr_data  = res_q;
    assign illegal  = illegal_q;

    assert_base_write_R2: assert property (@(posedge clk) disable iff (rst)
        (accept && dec_op == FOP_BASE) |=> (wr_en && wr_addr == $past(in_insn[25:21])));

    assert_ext_read_R6: assert property (@(posedge clk) disable iff (rst)
        (accept && dec_op == FOP_EXT) |=> (rd_en && !wr_en && rd_addr == $past(in_insn[25:21])));

    assert_rmw_same_reg_R6: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (wr_en && wr_addr == $past(rd_addr)));

    assert_bad_no_access_R10: assert property (@(posedge clk) disable iff (rst)
        (accept && dec_op == FOP_BAD) |=> (illegal && !wr_en && !rd_en));

    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) |-> !in_ready);

    assert_release_after_write_R9: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> in_ready);
endmodule

// File: tb/sim_fimm_unit.sv
module sim_fimm_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] MAJ = 6'd22;
    localparam logic [4:0] XB  = 5'd3;
    localparam logic [4:0] XE  = 5'd4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_insn = '0;
    logic        rd_en;
    logic [4:0]  rd_addr;
    logic [63:0] rd_data;
    logic        wr_en;
    logic [4:0]  wr_addr;
    logic [63:0] wr_data;
    logic        illegal;

    logic [63:0] fregs [32];
    logic        pre_en = 1'b0;
    logic [4:0]  pre_addr = '0;
    logic [63:0] pre_data = '0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [4:0]  q_addr [$];
    logic [63:0] q_data [$];
    string       q_req  [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fimm_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_insn(in_insn), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .illegal(illegal)
    );

    assign rd_data = fregs[rd_addr];

    always @(posedge clk) begin
        if (pre_en) fregs[pre_addr] <= pre_data;
        else if (wr_en) fregs[wr_addr] <= wr_data;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: every write is popped from the scoreboard and compared
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            if (q_addr.size() == 0) begin
                chk(1'b0, "R10", "unexpected write", {59'd0, wr_addr}, 64'd0);
            end else begin
                logic [4:0]  ea;
                logic [63:0] ed;
                string       er;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                er = q_req.pop_front();
                chk(wr_addr == ea, er, "write address", {59'd0, wr_addr}, {59'd0, ea});
                chk(wr_data == ed, er, "write data", wr_data, ed);
            end
        end
    end

    function automatic logic [31:0] mk(input logic [5:0] maj, input logic [4:0] xo,
                                       input logic [4:0] tgt, input logic [15:0] imm);
        return {maj, tgt, imm[5:1], imm[15:6], xo, imm[0]};
    endfunction

    // kind: 0 base, 1 extend, 2 illegal
    task automatic issue(input logic [31:0] insn, input int kind, input logic [4:0] tgt,
                         input logic [63:0] exp, input string req);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        if (kind != 2) begin
            q_addr.push_back(tgt);
            q_data.push_back(exp);
            q_req.push_back(req);
        end
        in_valid = 1'b1;
        in_insn  = insn;
        @(negedge clk);
        in_valid = 1'b0;
        chk(illegal == (kind == 2), "R10", "illegal flag", {63'd0, illegal}, {63'd0, kind == 2});
        if (kind == 0) begin
            chk(wr_en == 1'b1, "R2", "write one cycle after accept", {63'd0, wr_en}, 64'd1);
            chk(in_ready == 1'b0, "R9", "busy during write", {63'd0, in_ready}, 64'd0);
        end else if (kind == 1) begin
            chk(rd_en && !wr_en && rd_addr == tgt, "R6", "read cycle",
                {58'd0, rd_en, rd_addr}, {58'd1, tgt});
            @(negedge clk);
            chk(wr_en == 1'b1, "R6", "write two cycles after accept", {63'd0, wr_en}, 64'd1);
            chk(in_ready == 1'b0, "R9", "busy during write", {63'd0, in_ready}, 64'd0);
        end else begin
            chk(!wr_en && !rd_en, "R10", "no access", {62'd0, rd_en, wr_en}, 64'd0);
            @(negedge clk);
            chk(!wr_en && !rd_en && !illegal, "R10", "quiet after flag",
                {61'd0, illegal, rd_en, wr_en}, 64'd0);
        end
    endtask

    task automatic preload(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        pre_en = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 32; i++) fregs[i] = 64'd0;
        preload(5'd7, 64'h3FF0000FFFFFFFFF);
        preload(5'd9, 64'h47F0000000000000);
        repeat (2) @(negedge clk);
        chk(in_ready && !rd_en && !wr_en && !illegal, "R11", "reset state",
            {60'd0, in_ready, rd_en, wr_en, illegal}, 64'h8);
        rst = 1'b0;

        issue(mk(MAJ, XB, 5'd1,  16'h3F80), 0, 5'd1,  64'h3FF0000000000000, "R2 R3 one");
        issue(mk(MAJ, XB, 5'd2,  16'h0000), 0, 5'd2,  64'h0000000000000000, "R5 pos zero");
        issue(mk(MAJ, XB, 5'd3,  16'h8000), 0, 5'd3,  64'h8000000000000000, "R5 neg zero");
        issue(mk(MAJ, XB, 5'd4,  16'h7F80), 0, 5'd4,  64'h7FF0000000000000, "R5 infinity");
        issue(mk(MAJ, XB, 5'd5,  16'h7FC0), 0, 5'd5,  64'h7FF8000000000000, "R5 quiet NaN");
        issue(mk(MAJ, XB, 5'd6,  16'h0040), 0, 5'd6,  64'h3800000000000000, "R4 subnormal top");
        issue(mk(MAJ, XB, 5'd8,  16'h0001), 0, 5'd8,  64'h37A0000000000000, "R4 R1 subnormal d2 bit");
        issue(mk(MAJ, XB, 5'd10, 16'h0060), 0, 5'd10, 64'h3808000000000000, "R4 subnormal fraction");
        issue(mk(MAJ, XB, 5'd11, 16'hC049), 0, 5'd11, 64'hC009200000000000, "R3 R1 negative");
        issue(mk(MAJ, XE, 5'd11, 16'h0FDB), 1, 5'd11, 64'hC00921FB60000000, "R7 R9 back to back");
        issue(mk(MAJ, XE, 5'd1,  16'h0001), 1, 5'd1,  64'h3FF0000020000000, "R6 R1 low bit");
        issue(mk(MAJ, XE, 5'd1,  16'hFFFF), 1, 5'd1,  64'h3FF01FFFE0000000, "R6 R9 repeat extend");
        issue(mk(MAJ, XE, 5'd6,  16'h0001), 1, 5'd6,  64'h3800000040000000, "R8 subnormal narrow");
        issue(mk(MAJ, XE, 5'd7,  16'h1234), 1, 5'd7,  64'h3FF0024680000000, "R8 truncation");
        issue(mk(MAJ, XE, 5'd9,  16'h0000), 1, 5'd9,  64'h47EFE00000000000, "R8 overflow clamp");
        issue(mk(MAJ, XE, 5'd4,  16'hFFFF), 1, 5'd4,  64'h7FF01FFFE0000000, "R5 NaN payload");
        issue(mk(MAJ, 5'd31, 5'd1, 16'hABCD), 2, 5'd1, 64'd0, "R10 bad xo");
        issue(mk(6'd0, XB, 5'd1, 16'hABCD), 2, 5'd1, 64'd0, "R10 bad major");
        issue(mk(MAJ, XE, 5'd1,  16'h0000), 1, 5'd1,  64'h3FF0000000000000, "R10 register kept");

        repeat (3) @(negedge clk);
        chk(q_addr.size() == 0, "R2", "all writes seen", 64'(q_addr.size()), 64'd0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 watchdog expired: actual hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule